// File: doc/BRIEF.md
# Program Memory Checksum Walker

The block adds up a range of program memory words into a 16-bit checksum, as a power-up or on-demand integrity check. A pulse on `start_i` latches an end address, clears the sum and a two-byte word pointer, then walks the pointer upward from 0000h. For each address it issues one read request, takes the returned 16-bit word and folds it into the sum. It stops after the word at the end address has been added and pulses `done_o`.

Two places in the memory are never read. The small reserved window 0004h..0007h holds words that can differ between devices, so the walk hops from 0003h straight to 0008h. The topmost word of the memory is treated the same way. An end address that falls in either excluded place is clamped, so every run ends on a word that is actually summed.

Reads use a valid/ready request channel (`rom_req_o`/`rom_gnt_i`) carrying the address. When `rom_req_o` is high and `rom_gnt_i` is low, the request and its address are held. At most one read is outstanding. The response channel has no ready: `rom_rvalid_i` marks a word in `rom_rdata_i`, and the engine always accepts it in that cycle. `start_i`, `done_o` and `checksum_o` are plain control and status pins.

Top module: `rom_checksum`

## Requirements
- R1: A `start_i` pulse while the engine is idle samples `end_addr_i`, clears the checksum to 0000h, and the first read request is for address 0000h.
- R2: Addresses 0004h through 0007h are never requested; the request that follows address 0003h is for address 0008h.
- R3: The top memory word (all address bits one, 03FFh at the default width) is never requested; a sampled end address above the top word minus one is treated as the top word minus one.
- R4: A sampled end address from 0004h to 0007h is treated as 0003h, so the walk covers 0000h..0003h only.
- R5: Outside the reserved hop, each request is for the previous address plus one; the low pointer byte wraps from FFh to 00h and carries one into the high byte (00FFh is followed by 0100h).
- R6: For each returned word, its low byte is added to the low byte of the sum, and its high byte plus that addition's carry is added to the high byte of the sum. The final checksum therefore equals the modulo-65536 sum of all included words from 0000h through the effective end address.
- R7: `rom_req_o` stays high with `rom_addr_o` unchanged until a cycle with `rom_gnt_i` high. No new request is made until the word for the granted one has arrived on `rom_rvalid_i`.
- R8: `done_o` is high for exactly one cycle, the cycle after the word for the end address is accepted, and `checksum_o` then keeps its value until the next accepted start.
- R9: A `start_i` pulse while a walk is in progress has no effect: neither the end address nor the sum of the running walk changes.
- R10: After reset, `rom_req_o` and `done_o` are low and `checksum_o` is 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| end_addr_i | input | ADDR_W | Last address to include, sampled at start |
| rom_req_o | output | 1 | Read request valid |
| rom_gnt_i | input | 1 | Read request ready |
| rom_addr_o | output | ADDR_W | Word address of the request |
| rom_rvalid_i | input | 1 | Read data valid |
| rom_rdata_i | input | DATA_W | Returned program word |
| checksum_o | output | DATA_W | Running / final checksum |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that the memory side behaves as a single-outstanding responder. `rom_rvalid_i` rises only once per granted request, after the grant, and never while a request is still waiting. `start_i` is treated as a level sampled each cycle. The bench's memory model keeps to this: it records the granted address, returns exactly one word after a latency of zero to three cycles, and drives the grant either constantly high or randomly with back-pressure. The bench sweeps end addresses at a reduced 9-bit address width. The sweep covers every low end address, every address across the FFh-to-100h byte carry, and the top of memory, including the values that clamp.

// File: rtl/cks_pkg.sv
package cks_pkg;

  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_REQ  = 2'd1,
    CK_WAIT = 2'd2
  } cks_state_e;

  localparam int unsigned PTR_LO_W = 8;

endpackage

// File: rtl/cks_end_clamp.sv
module cks_end_clamp #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned RSV_FIRST = 4,
  parameter int unsigned RSV_LAST  = 7
) (
  input  logic [ADDR_W-1:0] raw_i,
  output logic [ADDR_W-1:0] eff_o
);

  localparam logic [ADDR_W-1:0] TOP_WORD  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MAX_END   = TOP_WORD - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WIN_LO    = ADDR_W'(RSV_FIRST);
  localparam logic [ADDR_W-1:0] WIN_HI    = ADDR_W'(RSV_LAST);
  localparam logic [ADDR_W-1:0] BELOW_WIN = ADDR_W'(RSV_FIRST - 1);

  logic above_top;
  logic in_window;

  always_comb begin
    above_top = (raw_i > MAX_END);
    in_window = (raw_i >= WIN_LO) && (raw_i <= WIN_HI);
    if (above_top) begin
      eff_o = MAX_END;
    end else if (in_window) begin
      eff_o = BELOW_WIN;
    end else begin
      eff_o = raw_i;
    end
  end

endmodule

// File: rtl/cks_ptr.sv
module cks_ptr
  import cks_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned RSV_FIRST = 4,
  parameter int unsigned RSV_LAST  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned LO_W = PTR_LO_W;
  localparam int unsigned HI_W = ADDR_W - LO_W;
  localparam logic [ADDR_W-1:0] HOP_FROM = ADDR_W'(RSV_FIRST);
  localparam logic [ADDR_W-1:0] HOP_TO   = ADDR_W'(RSV_LAST + 1);

  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_inc;
  logic              lo_wrap;
  logic [HI_W-1:0]   hi_inc;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] next_addr;

  // low byte steps on its own; its wrap is the only way the high byte moves
  always_comb begin
    {lo_wrap, lo_inc} = {1'b0, lo_q} + {{LO_W{1'b0}}, 1'b1};
    hi_inc            = hi_q + {{(HI_W-1){1'b0}}, lo_wrap};
    stepped           = {hi_inc, lo_inc};
    next_addr         = (stepped == HOP_FROM) ? HOP_TO : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clear_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (adv_i) begin
      lo_q <= next_addr[LO_W-1:0];
      hi_q <= next_addr[ADDR_W-1:LO_W];
    end
  end

  assign addr_o = {hi_q, lo_q};

endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] sum_o
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lo_nxt;
  logic [BYTE_W-1:0] hi_nxt;
  logic              lo_cy;

  always_comb begin
    {lo_cy, lo_nxt} = {1'b0, lo_q} + {1'b0, word_i[BYTE_W-1:0]};
    hi_nxt          = hi_q + word_i[DATA_W-1:BYTE_W] + {{(BYTE_W-1){1'b0}}, lo_cy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clear_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (add_i) begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
    end
  end

  assign sum_o = {hi_q, lo_q};

endmodule

// File: rtl/cks_ctrl.sv
module cks_ctrl
  import cks_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] end_eff_i,
  input  logic [ADDR_W-1:0] ptr_addr_i,
  input  logic              rom_gnt_i,
  input  logic              rom_rvalid_i,
  output logic              rom_req_o,
  output logic              ptr_clear_o,
  output logic              ptr_adv_o,
  output logic              acc_clear_o,
  output logic              acc_add_o,
  output logic              done_o,
  output logic              busy_o
);

  localparam int unsigned LO_W = PTR_LO_W;

  cks_state_e        state_q;
  cks_state_e        state_d;
  logic [ADDR_W-1:0] end_q;
  logic              done_q;
  logic              accept;
  logic              lo_match;
  logic              hi_match;
  logic              at_end;
  logic              word_in;

  always_comb begin
    accept   = (state_q == CK_IDLE) && start_i;
    lo_match = (ptr_addr_i[LO_W-1:0] == end_q[LO_W-1:0]);
    hi_match = (ptr_addr_i[ADDR_W-1:LO_W] == end_q[ADDR_W-1:LO_W]);
    at_end   = lo_match && hi_match;
    word_in  = (state_q == CK_WAIT) && rom_rvalid_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CK_IDLE: if (start_i)      state_d = CK_REQ;
      CK_REQ:  if (rom_gnt_i)    state_d = CK_WAIT;
      CK_WAIT: if (rom_rvalid_i) state_d = at_end ? CK_IDLE : CK_REQ;
      default:                   state_d = CK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CK_IDLE;
      end_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= word_in && at_end;
      if (accept) begin
        end_q <= end_eff_i;
      end
    end
  end

  assign rom_req_o   = (state_q == CK_REQ);
  assign ptr_clear_o = accept;
  assign acc_clear_o = accept;
  assign acc_add_o   = word_in;
  assign ptr_adv_o   = word_in && !at_end;
  assign done_o      = done_q;
  assign busy_o      = (state_q != CK_IDLE);

endmodule

// File: rtl/rom_checksum.sv
module rom_checksum #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RSV_FIRST = 4,
  parameter int unsigned RSV_LAST  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic              rom_req_o,
  input  logic              rom_gnt_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic              rom_rvalid_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [DATA_W-1:0] checksum_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] end_eff;
  logic [ADDR_W-1:0] ptr_addr;
  logic              ptr_clear;
  logic              ptr_adv;
  logic              acc_clear;
  logic              acc_add;
  logic              busy;

  cks_end_clamp #(
    .ADDR_W   (ADDR_W),
    .RSV_FIRST(RSV_FIRST),
    .RSV_LAST (RSV_LAST)
  ) u_clamp (
    .raw_i(end_addr_i),
    .eff_o(end_eff)
  );

  cks_ptr #(
    .ADDR_W   (ADDR_W),
    .RSV_FIRST(RSV_FIRST),
    .RSV_LAST (RSV_LAST)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(ptr_clear),
    .adv_i  (ptr_adv),
    .addr_o (ptr_addr)
  );

  cks_accum #(
    .DATA_W(DATA_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(acc_clear),
    .add_i  (acc_add),
    .word_i (rom_rdata_i),
    .sum_o  (checksum_o)
  );

  cks_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .end_eff_i   (end_eff),
    .ptr_addr_i  (ptr_addr),
    .rom_gnt_i   (rom_gnt_i),
    .rom_rvalid_i(rom_rvalid_i),
    .rom_req_o   (rom_req_o),
    .ptr_clear_o (ptr_clear),
    .ptr_adv_o   (ptr_adv),
    .acc_clear_o (acc_clear),
    .acc_add_o   (acc_add),
    .done_o      (done_o),
    .busy_o      (busy)
  );

  assign rom_addr_o = ptr_addr;

endmodule

// File: rtl/cks_checker.sv
module cks_checker #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RSV_FIRST = 4,
  parameter int unsigned RSV_LAST  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy,
  input logic              rom_req_o,
  input logic              rom_gnt_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [DATA_W-1:0] checksum_o,
  input logic              done_o
);

  localparam logic [ADDR_W-1:0] TOP_WORD = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(RSV_FIRST);
  localparam logic [ADDR_W-1:0] WIN_HI   = ADDR_W'(RSV_LAST);

  logic              fin_q;
  logic              have_q;
  logic              first_q;
  logic [ADDR_W-1:0] last_q;
  logic              taken;

  assign taken = start_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q   <= 1'b0;
      have_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= '0;
    end else if (taken) begin
      fin_q   <= 1'b0;
      have_q  <= 1'b0;
      first_q <= 1'b1;
    end else begin
      if (done_o) fin_q <= 1'b1;
      if (rom_req_o && rom_gnt_i) begin
        have_q  <= 1'b1;
        first_q <= 1'b0;
        last_q  <= rom_addr_o;
      end
    end
  end

  AST_FIRST_REQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o && first_q |-> rom_addr_o == '0); // R1
  AST_SKIP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o |-> (rom_addr_o < WIN_LO) || (rom_addr_o > WIN_HI)); // R2
  AST_NO_TOP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o |-> rom_addr_o != TOP_WORD); // R3
  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o && have_q |-> rom_addr_o > last_q); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req_o && !rom_gnt_i |=> rom_req_o && $stable(rom_addr_o)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rom_req_o); // R8
  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q && !taken |=> $stable(checksum_o)); // R8

endmodule

bind rom_checksum cks_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .RSV_FIRST(RSV_FIRST),
  .RSV_LAST (RSV_LAST)
) u_cks_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy      (busy),
  .rom_req_o (rom_req_o),
  .rom_gnt_i (rom_gnt_i),
  .rom_addr_o(rom_addr_o),
  .checksum_o(checksum_o),
  .done_o    (done_o)
);

// File: tb/tb_rom_checksum.sv
`timescale 1ns/1ps
module tb_rom_checksum;

  localparam int AW   = 9;
  localparam int DW   = 16;
  localparam int TOP  = (1 << AW) - 1;
  localparam int LOGN = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] end_addr_i = '0;
  logic          rom_req_o;
  logic          rom_gnt_i = 1'b0;
  logic [AW-1:0] rom_addr_o;
  logic          rom_rvalid_i = 1'b0;
  logic [DW-1:0] rom_rdata_i = '0;
  logic [DW-1:0] checksum_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic          bp_mode = 1'b0;
  logic          req_q = 1'b0;
  logic          gnt_q = 1'b0;
  logic [AW-1:0] addr_q = '0;
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int            lat = 0;
  int            log_n = 0;
  int            stall_err = 0;
  int            log_addr [LOGN];
  int            exp_addr [LOGN];

  always #2 clk = ~clk;

  rom_checksum #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_addr_i(end_addr_i),
    .rom_req_o(rom_req_o), .rom_gnt_i(rom_gnt_i), .rom_addr_o(rom_addr_o),
    .rom_rvalid_i(rom_rvalid_i), .rom_rdata_i(rom_rdata_i),
    .checksum_o(checksum_o), .done_o(done_o)
  );

  function automatic logic [DW-1:0] rom_word(input int a);
    logic [31:0] t;
    t = (32'(a) * 32'd40503 + 32'd4660) ^ (32'(a) << 7);
    return t[15:0];
  endfunction

  function automatic int clamp_end(input int e);
    if (e > TOP - 1) return TOP - 1;
    if (e >= 4 && e <= 7) return 3;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // single-outstanding memory responder, acts on falling edges
  always @(negedge clk) begin
    rom_rvalid_i = 1'b0;
    if (!rst_n) begin
      pend = 1'b0; req_q = 1'b0; gnt_q = 1'b0; rom_gnt_i = 1'b0;
    end else begin
      if (req_q && gnt_q) begin
        pend  = 1'b1;
        paddr = addr_q;
        lat   = bp_mode ? int'($urandom_range(0, 3)) : 0;
        log_addr[log_n % LOGN] = int'(addr_q);
        log_n++;
      end else if (req_q && !gnt_q && (!rom_req_o || rom_addr_o != addr_q)) begin
        stall_err++;
      end
      if (pend) begin
        if (lat == 0) begin
          rom_rvalid_i = 1'b1;
          rom_rdata_i  = rom_word(int'(paddr));
          pend = 1'b0;
        end else begin
          lat--;
        end
      end
      rom_gnt_i = bp_mode ? ($urandom_range(0, 1) == 1) : 1'b1;
      req_q  = rom_req_o;
      addr_q = rom_addr_o;
      gnt_q  = rom_gnt_i;
    end
  end

  task automatic run(input int e, input bit bp, input bit mid, input int alt, input string tag);
    int eff, n, base, guard, mism, stall0;
    logic [DW-1:0] sum, held;
    eff = clamp_end(e);
    n = 0; sum = '0;
    for (int a = 0; a <= eff; a++) begin
      if (a >= 4 && a <= 7) continue;
      exp_addr[n] = a;
      n++;
      sum = sum + rom_word(a);
    end
    @(negedge clk);
    bp_mode = bp;
    base = log_n;
    stall0 = stall_err;
    start_i = 1'b1;
    end_addr_i = AW'(e);
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (mid && guard == 6) begin start_i = 1'b1; end_addr_i = AW'(alt); end
      if (mid && guard == 7) start_i = 1'b0;
    end
    start_i = 1'b0;
    check(done_o, {tag, " R8 done seen"}, int'(done_o), 1);
    check(checksum_o == sum, {tag, " R6 checksum"}, int'(checksum_o), int'(sum));
    check(log_n - base == n, {tag, " R1 R2 R3 R4 request count"}, log_n - base, n);
    mism = 0;
    for (int k = 0; k < n && k < log_n - base; k++)
      if (log_addr[(base + k) % LOGN] != exp_addr[k]) mism++;
    check(mism == 0, {tag, " R1 R2 R5 address walk"}, mism, 0);
    if (bp) check(stall_err == stall0, {tag, " R7 request held"}, stall_err - stall0, 0);
    held = checksum_o;
    @(negedge clk);
    check(!done_o, {tag, " R8 done one cycle"}, int'(done_o), 0);
    @(negedge clk);
    @(negedge clk);
    check(checksum_o == held, {tag, " R8 checksum holds"}, int'(checksum_o), int'(held));
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!rom_req_o, "R10 req low in reset", int'(rom_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rom_req_o, "R10 req low after reset", int'(rom_req_o), 0);
    check(!done_o, "R10 done low after reset", int'(done_o), 0);
    check(checksum_o == '0, "R10 checksum zero", int'(checksum_o), 0);

    // low ends, includes the R4 clamp values 4..7
    for (int e = 0; e < 16; e++) run(e, 1'b0, 1'b0, 0, "low-end R4");
    // byte carry region, R5
    for (int e = 'hF0; e < 'h110; e++) run(e, 1'b0, 1'b0, 0, "carry R5");
    // top of memory, R3 clamp
    for (int e = TOP - 15; e <= TOP; e++) run(e, 1'b0, 1'b0, 0, "top R3");
    // back-pressure and variable latency, R7
    run(TOP, 1'b1, 1'b0, 0, "bp R7");
    run('h123, 1'b1, 1'b0, 0, "bp R7");
    run('hFF, 1'b1, 1'b0, 0, "bp R7");
    run(9, 1'b1, 1'b0, 0, "bp R7");
    run(5, 1'b1, 1'b0, 0, "bp R4");
    // start while busy, R9
    run('h80, 1'b0, 1'b1, 'h10, "busy-start R9");
    run('h40, 1'b1, 1'b1, TOP, "busy-start R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule